// File: doc/BRIEF.md
# Triggered Control Pattern Sequencer

This block drives a bank of control lines to an external sensor or converter chip. The waveforms come from a writable pattern memory, so timing can be changed by loading new words instead of rebuilding logic. Each memory word carries the control bits, a hold count, a serial-shift marker and an end marker. Three base/length pairs split the memory into an initialization region, an idle-loop region and a readout region.

Raising the run enable plays the initialization region once and then loops the idle region indefinitely. A rising edge on the chip's trigger input, seen while the idle region is looping, moves the block into the readout region at the next idle word boundary. In the readout region, words marked for shifting emit a one-cycle shift clock pulse. The serial result bit is sampled on the same clock edge. After the configured number of bits, the assembled word is converted from Gray code to binary and presented with a one-cycle strobe. When the readout region ends, the block goes back to the idle loop.

Top module: `ctl_pattern_seq`

## Requirements
- R1: A pattern memory write (`wr_en_i`) takes effect only while `run_en_i` is low. A write made while `run_en_i` is high leaves the memory unchanged.
- R2: When `run_en_i` rises, the block starts at offset 0 of the initialization region; that word appears on `ctl_o` one cycle later. While `run_en_i` is low, `ctl_o` is zero and `sclk_o` is low from the next cycle on.
- R3: A memory word has control bits [CTL_W-1:0], hold count [CTL_W+CNT_W-1:CTL_W], shift marker at bit CTL_W+CNT_W and end marker at bit CTL_W+CNT_W+1 (with defaults: [13:0], [21:14], 22, 23). A word stays on `ctl_o` for hold+1 cycles.
- R4: A region ends after its word at offset length-1, or after a word carrying the end marker, whichever comes first. A length of zero acts as one. The initialization region plays once, then the idle region repeats from its base.
- R5: `trig_i` passes through a two-stage synchronizer. A rising edge seen while the idle region runs moves the block to the readout region at the next idle word boundary. A rising edge during initialization is ignored.
- R6: Each readout word with its shift marker set drives `sclk_o` high for one cycle, starting when that word starts. `sdata_i` is sampled on the same edge. Bits arrive MSB first, DATA_W bits per result.
- R7: After the last bit of a result is sampled, `dout_o` holds the binary value of the Gray-coded bits and `dvalid_o` is high for exactly one cycle.
- R8: When the readout region ends, the block resumes the idle region from its base.
- R9: While `rst_ni` is low, `ctl_o`, `sclk_o` and `dvalid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Run enable; rising edge restarts at the initialization region |
| wr_en_i | input | 1 | Pattern memory write strobe |
| wr_addr_i | input | ADDR_W | Pattern memory write address |
| wr_data_i | input | CTL_W+CNT_W+2 | Pattern memory write word |
| init_base_i | input | ADDR_W | Initialization region base address |
| init_len_i | input | ADDR_W+1 | Initialization region length in words |
| loop_base_i | input | ADDR_W | Idle region base address |
| loop_len_i | input | ADDR_W+1 | Idle region length in words |
| read_base_i | input | ADDR_W | Readout region base address |
| read_len_i | input | ADDR_W+1 | Readout region length in words |
| trig_i | input | 1 | Trigger from the external chip (asynchronous) |
| sdata_i | input | 1 | Serial result bit from the external chip |
| ctl_o | output | CTL_W | Control lines |
| sclk_o | output | 1 | Serial shift clock pulse |
| dout_o | output | DATA_W | Decoded binary result |
| dvalid_o | output | 1 | One-cycle strobe for `dout_o` |

## Verification
Most internal faults appear on `ctl_o` within one word time:
- a wrong region offset or hold counter shows a pattern value in the wrong cycle or a word held for the wrong number of cycles;
- a broken phase change shows readout values where idle values belong.

A fault in the trigger path shows as a missing or spurious readout within a few cycles of the trigger edge. A wrong bit count or a wrong Gray decode shows as a wrong count of `sclk_o` pulses or a wrong `dout_o`. Either is visible no later than the strobe that ends each readout.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
    typedef enum logic [1:0] {
        PH_STOP = 2'd0,
        PH_INIT = 2'd1,
        PH_LOOP = 2'd2,
        PH_READ = 2'd3
    } phase_e;
endpackage

// File: rtl/ctl_pat_mem.sv
module ctl_pat_mem #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 24,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WIDTH-1:0]  rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // asynchronous read: the next word is available in the cycle its predecessor ends
    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ctl_trig_sync.sv
module ctl_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_gray2bin.sv
module ctl_gray2bin #(
    parameter int W = 8
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    assign bin_o[W-1] = gray_i[W-1];

    generate
        for (genvar i = W - 2; i >= 0; i--) begin : g_bit
            assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
        end
    endgenerate
endmodule

// File: rtl/ctl_ser_gray.sv
module ctl_ser_gray #(
    parameter int DATA_W = 8,
    localparam int CW    = $clog2(DATA_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              sample_i,
    input  logic              sdata_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dvalid_o
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] dout;
        logic              vld;
    } des_t;

    des_t des_d, des_q;
    logic [DATA_W-1:0] sh_next;
    logic [DATA_W-1:0] bin;

    assign sh_next = {des_q.sh[DATA_W-2:0], sdata_i};

    ctl_gray2bin #(.W(DATA_W)) gray_i (
        .gray_i (sh_next),
        .bin_o  (bin)
    );

    always_comb begin
        des_d     = des_q;
        des_d.vld = 1'b0;
        if (clr_i) begin
            des_d.cnt = '0;
        end
        if (sample_i) begin
            des_d.sh = sh_next;
            if (des_d.cnt == CW'(DATA_W - 1)) begin
                des_d.cnt  = '0;
                des_d.dout = bin;
                des_d.vld  = 1'b1;
            end else begin
                des_d.cnt = des_d.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) des_q <= '0;
        else         des_q <= des_d;
    end

    assign dout_o   = des_q.dout;
    assign dvalid_o = des_q.vld;
endmodule

// File: rtl/ctl_pattern_seq.sv
module ctl_pattern_seq
    import ctl_seq_pkg::*;
#(
    parameter int  CTL_W     = 14,
    parameter int  CNT_W     = 8,
    parameter int  DEPTH     = 32,
    parameter int  DATA_W    = 8,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int LEN_W     = ADDR_W + 1,
    localparam int WORD_BITS = CTL_W + CNT_W + 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 run_en_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [WORD_BITS-1:0] wr_data_i,
    input  logic [ADDR_W-1:0]    init_base_i,
    input  logic [LEN_W-1:0]     init_len_i,
    input  logic [ADDR_W-1:0]    loop_base_i,
    input  logic [LEN_W-1:0]     loop_len_i,
    input  logic [ADDR_W-1:0]    read_base_i,
    input  logic [LEN_W-1:0]     read_len_i,
    input  logic                 trig_i,
    input  logic                 sdata_i,
    output logic [CTL_W-1:0]     ctl_o,
    output logic                 sclk_o,
    output logic [DATA_W-1:0]    dout_o,
    output logic                 dvalid_o
);
    localparam int SHIFT_BIT = CTL_W + CNT_W;
    localparam int LAST_BIT  = CTL_W + CNT_W + 1;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] off;
        logic [CNT_W-1:0]  hold;
        logic              last;
        logic [CTL_W-1:0]  ctl;
        logic              sclk;
        logic              pend;
        logic              trig_prev;
        logic              run_prev;
    } seq_t;

    seq_t st_d, st_q;
    phase_e phase_q;

    logic                 trig_s;
    logic                 trig_rise;
    logic                 reg_end;
    logic [LEN_W-1:0]     cur_len;
    logic                 ld_en;
    phase_e               ld_phase;
    logic [ADDR_W-1:0]    ld_off;
    logic [ADDR_W-1:0]    ld_base;
    logic [ADDR_W-1:0]    rd_addr;
    logic [WORD_BITS-1:0] rd_word;
    logic                 take_trig;
    logic                 smp;
    logic                 des_clr;

    ctl_pat_mem #(.DEPTH(DEPTH), .WIDTH(WORD_BITS)) mem_i (
        .clk_i   (clk_i),
        .we_i    (wr_en_i & ~run_en_i),
        .waddr_i (wr_addr_i),
        .wdata_i (wr_data_i),
        .raddr_i (rd_addr),
        .rdata_o (rd_word)
    );

    ctl_trig_sync #(.STAGES(2)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (trig_i),
        .q_o    (trig_s)
    );

    ctl_ser_gray #(.DATA_W(DATA_W)) des_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (des_clr),
        .sample_i (smp),
        .sdata_i  (sdata_i),
        .dout_o   (dout_o),
        .dvalid_o (dvalid_o)
    );

    // decision logic: which word loads next, and from where
    always_comb begin
        trig_rise = trig_s & ~st_q.trig_prev;
        take_trig = 1'b0;
        unique case (st_q.phase)
            PH_LOOP: cur_len = loop_len_i;
            PH_READ: cur_len = read_len_i;
            default: cur_len = init_len_i;
        endcase
        reg_end  = st_q.last || (({1'b0, st_q.off} + LEN_W'(1)) >= cur_len);
        ld_en    = 1'b0;
        ld_phase = PH_INIT;
        ld_off   = '0;
        if (run_en_i) begin
            if (!st_q.run_prev) begin
                ld_en = 1'b1;
            end else if (st_q.hold == '0) begin
                ld_en = 1'b1;
                unique case (st_q.phase)
                    PH_INIT: begin
                        if (reg_end) begin
                            ld_phase = PH_LOOP;
                        end else begin
                            ld_phase = PH_INIT;
                            ld_off   = st_q.off + ADDR_W'(1);
                        end
                    end
                    PH_LOOP: begin
                        if (st_q.pend || trig_rise) begin
                            ld_phase  = PH_READ;
                            take_trig = 1'b1;
                        end else if (reg_end) begin
                            ld_phase = PH_LOOP;
                        end else begin
                            ld_phase = PH_LOOP;
                            ld_off   = st_q.off + ADDR_W'(1);
                        end
                    end
                    PH_READ: begin
                        if (reg_end) begin
                            ld_phase = PH_LOOP;
                        end else begin
                            ld_phase = PH_READ;
                            ld_off   = st_q.off + ADDR_W'(1);
                        end
                    end
                    default: ld_phase = PH_INIT;
                endcase
            end
        end
        unique case (ld_phase)
            PH_LOOP: ld_base = loop_base_i;
            PH_READ: ld_base = read_base_i;
            default: ld_base = init_base_i;
        endcase
        rd_addr = ld_base + ld_off;
    end

    // next-state assembly from the decision and the fetched word
    always_comb begin
        st_d           = st_q;
        st_d.sclk      = 1'b0;
        st_d.trig_prev = trig_s;
        st_d.run_prev  = run_en_i;
        smp            = 1'b0;
        des_clr        = 1'b0;
        if (!run_en_i) begin
            st_d.phase = PH_STOP;
            st_d.off   = '0;
            st_d.hold  = '0;
            st_d.last  = 1'b0;
            st_d.ctl   = '0;
            st_d.pend  = 1'b0;
        end else begin
            if (st_q.phase == PH_LOOP && trig_rise) begin
                st_d.pend = 1'b1;
            end
            if (take_trig) begin
                st_d.pend = 1'b0;
            end
            if (st_q.run_prev && st_q.hold != '0) begin
                st_d.hold = st_q.hold - CNT_W'(1);
            end
            if (ld_en) begin
                st_d.phase = ld_phase;
                st_d.off   = ld_off;
                st_d.ctl   = rd_word[CTL_W-1:0];
                st_d.hold  = rd_word[CTL_W +: CNT_W];
                st_d.last  = rd_word[LAST_BIT];
                if (ld_phase == PH_READ) begin
                    des_clr   = (st_q.phase != PH_READ);
                    smp       = rd_word[SHIFT_BIT];
                    st_d.sclk = rd_word[SHIFT_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: PH_STOP, default: '0};
        else         st_q <= st_d;
    end

    assign phase_q = st_q.phase;
    assign ctl_o   = st_q.ctl;
    assign sclk_o  = st_q.sclk;
endmodule

// File: rtl/ctl_pattern_seq_chk.sv
module ctl_pattern_seq_chk
    import ctl_seq_pkg::*;
#(
    parameter int CTL_W = 14
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_en_i,
    input logic [CTL_W-1:0] ctl_o,
    input logic             sclk_o,
    input logic             dvalid_o,
    input phase_e           phase_q
);
    p_stop_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_en_i |=> (ctl_o == '0 && !sclk_o));

    p_start_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_en_i) |=> (phase_q == PH_INIT));

    p_init_no_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PH_INIT) |=> (phase_q != PH_READ));

    p_read_from_loop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PH_READ && $past(phase_q) != PH_READ) |-> ($past(phase_q) == PH_LOOP));

    p_sclk_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_o |-> (phase_q == PH_READ));

    p_strobe_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dvalid_o |=> !dvalid_o);

    p_read_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PH_READ && run_en_i) |=> (phase_q == PH_READ || phase_q == PH_LOOP));
endmodule

bind ctl_pattern_seq ctl_pattern_seq_chk #(.CTL_W(CTL_W)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_en_i (run_en_i),
    .ctl_o    (ctl_o),
    .sclk_o   (sclk_o),
    .dvalid_o (dvalid_o),
    .phase_q  (phase_q)
);

// File: tb/ctl_pattern_seq_tb_top.sv
module ctl_pattern_seq_tb_top;
    localparam int CTL_W  = 14;
    localparam int CNT_W  = 8;
    localparam int DEPTH  = 32;
    localparam int DATA_W = 8;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int LEN_W  = ADDR_W + 1;
    localparam int WB     = CTL_W + CNT_W + 2;

    localparam logic [CTL_W-1:0] LOOP_A = 14'h0A0A;
    localparam logic [CTL_W-1:0] LOOP_B = 14'h0505;
    localparam logic [CTL_W-1:0] RD_CTL = 14'h1000;
    localparam logic [CTL_W-1:0] RD_END = 14'h2000;

    // expected ctl_o per cycle after run enable rises (R2, R3, R4)
    localparam int NSEQ = 7;
    localparam logic [CTL_W-1:0] EXP_SEQ [NSEQ] = '{
        14'h0011, 14'h0011, 14'h0022, LOOP_A, LOOP_B, LOOP_A, LOOP_B
    };
    localparam int NRD = 4;
    localparam logic [DATA_W-1:0] RD_VALS [NRD] = '{8'hA5, 8'h3C, 8'hFF, 8'h01};

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              run_en_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [WB-1:0]     wr_data_i = '0;
    logic              trig_i = 1'b0;
    logic              sdata_i = 1'b0;
    logic [CTL_W-1:0]  ctl_o;
    logic              sclk_o;
    logic [DATA_W-1:0] dout_o;
    logic              dvalid_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ctl_pattern_seq #(.CTL_W(CTL_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .run_en_i    (run_en_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .init_base_i (5'd0),
        .init_len_i  (6'd2),
        .loop_base_i (5'd4),
        .loop_len_i  (6'd2),
        .read_base_i (5'd8),
        .read_len_i  (6'd12),
        .trig_i      (trig_i),
        .sdata_i     (sdata_i),
        .ctl_o       (ctl_o),
        .sclk_o      (sclk_o),
        .dout_o      (dout_o),
        .dvalid_o    (dvalid_o)
    );

    function automatic logic [WB-1:0] mk(input logic [CTL_W-1:0] c, input logic [CNT_W-1:0] h,
                                         input logic sh, input logic last);
        return {last, sh, h, c};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_word(input int a, input logic [WB-1:0] w);
        wr_en_i   = 1'b1;
        wr_addr_i = ADDR_W'(a);
        wr_data_i = w;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic do_readout(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] g;
        logic [DATA_W-1:0] got;
        int nsclk, nvld, bitn, dbl;
        bit zero_seen, rd_seen, prev_v;
        g = v ^ (v >> 1);
        got = '0; nsclk = 0; nvld = 0; bitn = 0; dbl = 0;
        zero_seen = 0; rd_seen = 0; prev_v = 0;
        sdata_i = g[DATA_W-1];
        trig_i  = 1'b1;
        for (int cyc = 0; cyc < 80; cyc++) begin
            @(negedge clk);
            if (cyc == 3) trig_i = 1'b0;
            if (ctl_o == '0) zero_seen = 1;
            if (ctl_o == RD_CTL) rd_seen = 1;
            if (sclk_o) begin
                nsclk++;
                bitn++;
                sdata_i = (bitn < DATA_W) ? g[DATA_W-1-bitn] : 1'b0;
            end
            if (dvalid_o) begin
                nvld++;
                got = dout_o;
                if (prev_v) dbl++;
            end
            prev_v = dvalid_o;
        end
        chk(nsclk == DATA_W, "R6 shift clock pulses per result", nsclk, DATA_W);
        chk(nvld == 1 && dbl == 0, "R7 single strobe per result", nvld, 1);
        chk(got == v, "R7 Gray decoded result", int'(got), int'(v));
        chk(rd_seen && !zero_seen, "R4 readout ends at end marker", int'(zero_seen), 0);
        chk(ctl_o == LOOP_A || ctl_o == LOOP_B, "R8 idle loop resumes", int'(ctl_o), int'(LOOP_A));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int nsclk;
        repeat (3) @(negedge clk);
        chk(ctl_o == '0, "R9 ctl zero in reset", int'(ctl_o), 0);
        chk(!sclk_o, "R9 sclk low in reset", int'(sclk_o), 0);
        chk(!dvalid_o, "R9 strobe low in reset", int'(dvalid_o), 0);
        rst_ni = 1'b1;
        @(negedge clk);

        // load pattern memory while stopped (R1)
        wr_word(0, mk(14'h0011, 8'd1, 1'b0, 1'b0));
        wr_word(1, mk(14'h0022, 8'd0, 1'b0, 1'b0));
        wr_word(4, mk(LOOP_A, 8'd0, 1'b0, 1'b0));
        wr_word(5, mk(LOOP_B, 8'd0, 1'b0, 1'b0));
        for (int i = 0; i < DATA_W; i++) wr_word(8 + i, mk(RD_CTL, 8'd1, 1'b1, 1'b0));
        wr_word(8 + DATA_W, mk(RD_END, 8'd0, 1'b0, 1'b1));

        // vector walk: init once, hold counts, idle loop (R2 R3 R4)
        run_en_i = 1'b1;
        for (int i = 0; i < NSEQ; i++) begin
            @(negedge clk);
            chk(ctl_o == EXP_SEQ[i], "R3/R4 pattern cycle", int'(ctl_o), int'(EXP_SEQ[i]));
        end

        // triggered readouts (R5 R6 R7 R8)
        for (int k = 0; k < NRD; k++) begin
            repeat (5) @(negedge clk);
            do_readout(RD_VALS[k]);
        end

        // write while running is ignored (R1); stop clears outputs (R2)
        wr_word(0, mk(14'h3FFF, 8'd0, 1'b0, 1'b0));
        run_en_i = 1'b0;
        @(negedge clk);
        chk(ctl_o == '0 && !sclk_o, "R2 outputs quiet when stopped", int'(ctl_o), 0);

        // restart with a trigger pulse during initialization (R1 R5)
        run_en_i = 1'b1;
        trig_i   = 1'b1;
        @(negedge clk);
        trig_i   = 1'b0;
        chk(ctl_o == 14'h0011, "R1 running write ignored", int'(ctl_o), 'h11);
        nsclk = 0;
        for (int c = 0; c < 25; c++) begin
            @(negedge clk);
            if (sclk_o) nsclk++;
        end
        chk(nsclk == 0, "R5 trigger during init ignored", nsclk, 0);
        chk(ctl_o == LOOP_A || ctl_o == LOOP_B, "R4 idle loop after init", int'(ctl_o), int'(LOOP_A));

        // write while stopped takes effect (R1), new hold count (R3)
        run_en_i = 1'b0;
        @(negedge clk);
        wr_word(0, mk(14'h0033, 8'd1, 1'b0, 1'b0));
        run_en_i = 1'b1;
        @(negedge clk);
        chk(ctl_o == 14'h0033, "R1 stopped write applied", int'(ctl_o), 'h33);
        @(negedge clk);
        chk(ctl_o == 14'h0033, "R3 word held hold+1 cycles", int'(ctl_o), 'h33);
        @(negedge clk);
        chk(ctl_o == 14'h0022, "R3 next word after hold", int'(ctl_o), 'h22);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule